// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Core

This block is a small processor that runs a word-addressed instruction set with eight general registers. Instructions and data live in one external memory reached through a single port. That port carries an address, write data, read data, an enable and a write select. Since the port can serve only one access per cycle, every instruction is spread over several clock cycles. A control state machine moves each instruction through fetch, decode, execute and, where needed, memory and writeback steps. Internal registers hold values between steps: the instruction register, the two operand latches, the ALU result register and the memory data register.

The instruction classes are add, nor, load word, store word, branch-if-equal, noop and halt. Each class takes a fixed number of cycles. Two counters run beside the datapath. One counts the cycles executed since reset and the other counts retired instructions, so the average cycles per instruction of a program can be read at the ports. The memory read data is expected in the same cycle as the address, which suits an asynchronous-read RAM or a bus with zero wait states.

Top module: `mcpu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, all eight registers (register 0 included), both counters and the halted flag. In the first cycle after reset, the core fetches from address 0.
- R2: The first cycle of every instruction is a memory read at the program counter: mem_en=1, mem_wr=0. The program counter then advances by one word.
- R3: Load word takes 5 cycles. In its 4th cycle it reads memory (mem_en=1, mem_wr=0) at regA plus the sign-extended 16-bit offset, and the word read is written to register regB.
- R4: Store word takes 4 cycles. In its 4th cycle it writes (mem_en=1, mem_wr=1) the contents of regB to address regA plus the sign-extended offset.
- R5: Add and nor take 4 cycles each. They write regA+regB, or the bitwise NOR of regA and regB, to the register named in instruction bits 2-0. They make no memory access after the fetch.
- R6: Branch-if-equal takes 4 cycles. When regA equals regB, the next fetch is from PC+1+offset, and the offset may be negative. Otherwise the next fetch is from PC+1.
- R7: Register 0 can be written and read like any other register.
- R8: Halt (opcode 110) takes 2 cycles and then raises halted. Once halted, the memory port stays idle and both counters hold. Noop (111) and the unused opcode 101 take 4 cycles and change no register or memory.
- R9: The cycle counter rises by one in every cycle that is not halted. The retired counter rises by one in the last cycle of each instruction, halt included. A program of 25 loads, 10 stores, 45 adds and 20 branches, followed by a halt, ends with 427 cycles and 101 retired.
- R10: Instruction fields sit at fixed positions: the opcode in bits 24-22, regA in bits 21-19, regB in bits 18-16 and the offset in bits 15-0. Opcodes are add 000, nor 001, lw 010, sw 011, beq 100, halt 110 and noop 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Word address of the current memory access |
| mem_wdata | output | WORD_W | Store data |
| mem_rdata | input | WORD_W | Read data, valid in the cycle the address is presented |
| mem_en | output | 1 | Memory access this cycle |
| mem_wr | output | 1 | 1 = write, 0 = read |
| halted | output | 1 | Core has executed halt |
| cycle_count | output | CNT_W | Cycles executed since reset |
| retired_count | output | CNT_W | Instructions completed since reset |

## Verification
The first stimulus is a long mix of loads, stores, adds and branches in a fixed interleave. Its final counts separate a correct cycle cost for each class from one that is off by a single cycle in any class. The second stimulus is a hand-written program. It writes register 0, uses nor results, runs a countdown loop closed by a backward branch with a forward exit, and loads through a negative offset. Its stored results show whether field decoding, sign extension and branch targets are correct. A reset in the middle of execution shows that every piece of state returns to its starting value. Every clock is compared against a behavioural model of the instruction set, so a port access in the wrong cycle or at the wrong address is reported at once.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  localparam int OPC_LSB  = 22;
  localparam int RA_LSB   = 19;
  localparam int RB_LSB   = 16;
  localparam int DST_LSB  = 0;
  localparam int OFF_W    = 16;
  localparam int RIDX_W   = 3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_NOR  = 3'b001,
    OP_LW   = 3'b010,
    OP_SW   = 3'b011,
    OP_BEQ  = 3'b100,
    OP_RSV  = 3'b101,
    OP_HALT = 3'b110,
    OP_NOOP = 3'b111
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_MEM,
    ST_WB,
    ST_BR,
    ST_HALT
  } state_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_NOR,
    ALU_ADDR,
    ALU_TGT
  } alu_fn_e;

endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int WORD_W = 32,
  parameter int NREGS  = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ra_data,
  output logic [WORD_W-1:0] rb_data
);

  logic [WORD_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

  // every index, 0 included, keeps what was written to it
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  alu_fn_e           fn,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic [WORD_W-1:0] pc_x,
  input  logic [WORD_W-1:0] off_x,
  output logic [WORD_W-1:0] result,
  output logic              equal
);

  always_comb begin
    unique case (fn)
      ALU_ADD:  result = opa + opb;
      ALU_NOR:  result = ~(opa | opb);
      ALU_ADDR: result = opa + off_x;
      default:  result = pc_x + off_x;
    endcase
  end

  assign equal = (opa == opb);

endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
  import mcpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e opc,
  output state_e  state,
  output alu_fn_e alu_fn,
  output logic    ld_ir,
  output logic    ld_ab,
  output logic    ld_alu,
  output logic    ld_eq,
  output logic    ld_mdr,
  output logic    rf_we,
  output logic    wb_from_mem,
  output logic    pc_inc,
  output logic    br_cycle,
  output logic    mem_en,
  output logic    mem_wr,
  output logic    retire,
  output logic    halted
);

  state_e nxt;

  always_comb begin
    nxt         = state;
    alu_fn      = ALU_ADD;
    ld_ir       = 1'b0;
    ld_ab       = 1'b0;
    ld_alu      = 1'b0;
    ld_eq       = 1'b0;
    ld_mdr      = 1'b0;
    rf_we       = 1'b0;
    wb_from_mem = 1'b0;
    pc_inc      = 1'b0;
    br_cycle    = 1'b0;
    mem_en      = 1'b0;
    mem_wr      = 1'b0;
    retire      = 1'b0;
    unique case (state)
      ST_FETCH: begin
        mem_en = 1'b1;
        ld_ir  = 1'b1;
        pc_inc = 1'b1;
        nxt    = ST_DECODE;
      end
      ST_DECODE: begin
        ld_ab = 1'b1;
        if (opc == OP_HALT) begin
          retire = 1'b1;
          nxt    = ST_HALT;
        end else begin
          nxt = ST_EXEC;
        end
      end
      ST_EXEC: begin
        ld_alu = 1'b1;
        unique case (opc)
          OP_LW, OP_SW: begin alu_fn = ALU_ADDR; nxt = ST_MEM; end
          OP_BEQ:       begin alu_fn = ALU_TGT; ld_eq = 1'b1; nxt = ST_BR; end
          OP_NOR:       begin alu_fn = ALU_NOR; nxt = ST_WB; end
          default:      begin alu_fn = ALU_ADD; nxt = ST_WB; end
        endcase
      end
      ST_MEM: begin
        mem_en = 1'b1;
        if (opc == OP_SW) begin
          mem_wr = 1'b1;
          retire = 1'b1;
          nxt    = ST_FETCH;
        end else begin
          ld_mdr = 1'b1;
          nxt    = ST_WB;
        end
      end
      ST_WB: begin
        rf_we       = (opc == OP_ADD) || (opc == OP_NOR) || (opc == OP_LW);
        wb_from_mem = (opc == OP_LW);
        retire      = 1'b1;
        nxt         = ST_FETCH;
      end
      ST_BR: begin
        br_cycle = 1'b1;
        retire   = 1'b1;
        nxt      = ST_FETCH;
      end
      default: nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      halted <= 1'b0;
    end else begin
      state  <= nxt;
      halted <= (nxt == ST_HALT);
    end
  end

  // a data access only ever follows address generation
  assert_mem_after_exec_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEM) |-> $past(state) == ST_EXEC);

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32,
  localparam int NREGS = 1 << RIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_en,
  output logic              mem_wr,
  output logic              halted,
  output logic [CNT_W-1:0]  cycle_count,
  output logic [CNT_W-1:0]  retired_count
);

  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] ir, opa_q, opb_q, alu_q, mdr_q;
  logic              eq_q;

  opcode_e           opc;
  logic [RIDX_W-1:0] ra_idx, rb_idx, dst_idx;
  logic [WORD_W-1:0] off_x, pc_x;

  assign opc     = opcode_e'(ir[OPC_LSB +: 3]);
  assign ra_idx  = ir[RA_LSB +: RIDX_W];
  assign rb_idx  = ir[RB_LSB +: RIDX_W];
  assign dst_idx = ir[DST_LSB +: RIDX_W];
  assign off_x   = {{(WORD_W-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};
  assign pc_x    = {{(WORD_W-ADDR_W){1'b0}}, pc};

  state_e  state;
  alu_fn_e alu_fn;
  logic    ld_ir, ld_ab, ld_alu, ld_eq, ld_mdr, rf_we, wb_from_mem;
  logic    pc_inc, br_cycle, retire;

  mcpu_ctrl ctrl_i (
    .clk(clk), .rst(rst), .opc(opc), .state(state), .alu_fn(alu_fn),
    .ld_ir(ld_ir), .ld_ab(ld_ab), .ld_alu(ld_alu), .ld_eq(ld_eq),
    .ld_mdr(ld_mdr), .rf_we(rf_we), .wb_from_mem(wb_from_mem),
    .pc_inc(pc_inc), .br_cycle(br_cycle), .mem_en(mem_en), .mem_wr(mem_wr),
    .retire(retire), .halted(halted)
  );

  logic [WORD_W-1:0] ra_data, rb_data, wr_data;
  logic [RIDX_W-1:0] wr_idx;

  assign wr_data = wb_from_mem ? mdr_q : alu_q;
  assign wr_idx  = wb_from_mem ? rb_idx : dst_idx;

  mcpu_regfile #(.WORD_W(WORD_W), .NREGS(NREGS)) rf_i (
    .clk(clk), .rst(rst), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .we(rf_we), .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_data(ra_data), .rb_data(rb_data)
  );

  logic [WORD_W-1:0] alu_res;
  logic              alu_eq;

  mcpu_alu #(.WORD_W(WORD_W)) alu_i (
    .fn(alu_fn), .opa(opa_q), .opb(opb_q), .pc_x(pc_x), .off_x(off_x),
    .result(alu_res), .equal(alu_eq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir    <= '0;
      opa_q <= '0;
      opb_q <= '0;
      alu_q <= '0;
      mdr_q <= '0;
      eq_q  <= 1'b0;
    end else begin
      if (ld_ir)  ir <= mem_rdata;
      if (pc_inc) pc <= pc + 1'b1;
      else if (br_cycle && eq_q) pc <= alu_q[ADDR_W-1:0];
      if (ld_ab) begin
        opa_q <= ra_data;
        opb_q <= rb_data;
      end
      if (ld_alu) alu_q <= alu_res;
      if (ld_eq)  eq_q  <= alu_eq;
      if (ld_mdr) mdr_q <= mem_rdata;
    end
  end

  assign mem_addr  = (state == ST_MEM) ? alu_q[ADDR_W-1:0] : pc;
  assign mem_wdata = opb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_count   <= '0;
      retired_count <= '0;
    end else begin
      if (!halted) cycle_count <= cycle_count + 1'b1;
      if (retire)  retired_count <= retired_count + 1'b1;
    end
  end

  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> pc == $past(pc) + 1'b1);

  assert_store_retires_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_wr) |=> retired_count == $past(retired_count) + 1'b1);

  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && !mem_en && $stable(cycle_count) && $stable(retired_count));

  assert_cycle_step_R9: assert property (@(posedge clk) disable iff (rst)
    !halted |=> cycle_count == $past(cycle_count) + 1'b1);

  assert_retire_step_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (retired_count == $past(retired_count)) ||
             (retired_count == $past(retired_count) + 1'b1));

endmodule

// File: tb/mcpu_core_tb.sv
module mcpu_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_en, mem_wr, halted;
  logic [31:0] cycle_count, retired_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcpu_core dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_wr(mem_wr),
    .halted(halted), .cycle_count(cycle_count), .retired_count(retired_count)
  );

  logic [31:0] ram [256];
  assign mem_rdata = ram[mem_addr[7:0]];
  always @(posedge clk) if (mem_en && mem_wr) ram[mem_addr[7:0]] <= mem_wdata;

  int n_chk = 0;
  int n_err = 0;
  int wd    = 0;

  always @(posedge clk) begin
    wd++;
    if (wd == WD_LIMIT) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected=finished run", wd);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [2:0] op, input int ra, input int rb,
                                      input logic [15:0] off);
    return {7'd0, op, ra[2:0], rb[2:0], off};
  endfunction

  // behavioural reference
  logic [31:0] m_rf [8];
  logic [31:0] m_mem [256];
  logic [15:0] m_pc;
  int          m_k, m_len, m_cycles, m_retired;
  bit          m_halted;
  logic [31:0] cur;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic m_begin();
    cur = m_mem[m_pc[7:0]];
    case (cur[24:22])
      3'b010:  m_len = 5;
      3'b110:  m_len = 2;
      default: m_len = 4;
    endcase
    m_k = 0;
  endtask

  task automatic m_reset();
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    m_pc = '0; m_cycles = 0; m_retired = 0; m_halted = 0;
    m_begin();
  endtask

  task automatic m_finish_instr();
    logic [31:0] a, b, ea;
    a  = m_rf[cur[21:19]];
    b  = m_rf[cur[18:16]];
    ea = a + sx(cur[15:0]);
    m_pc = m_pc + 16'd1;
    case (cur[24:22])
      3'b000: m_rf[cur[2:0]] = a + b;
      3'b001: m_rf[cur[2:0]] = ~(a | b);
      3'b010: m_rf[cur[18:16]] = m_mem[ea[7:0]];
      3'b011: m_mem[ea[7:0]] = b;
      3'b100: if (a == b) m_pc = m_pc + cur[15:0];
      3'b110: m_halted = 1;
      default: ;
    endcase
    m_retired++;
    if (!m_halted) m_begin();
  endtask

  task automatic compare_cycle();
    logic [31:0] ea;
    logic        e_en, e_wr;
    logic [15:0] e_addr;
    ea = m_rf[cur[21:19]] + sx(cur[15:0]);
    e_en = 0; e_wr = 0; e_addr = '0;
    if (!m_halted) begin
      if (m_k == 0) begin e_en = 1; e_addr = m_pc; end
      else if (m_k == 3 && cur[24:22] == 3'b010) begin e_en = 1; e_addr = ea[15:0]; end
      else if (m_k == 3 && cur[24:22] == 3'b011) begin e_en = 1; e_wr = 1; e_addr = ea[15:0]; end
    end
    chk("R9 cycle_count", cycle_count, m_cycles);
    chk("R9 retired_count", retired_count, m_retired);
    chk("R8 halted", {31'd0, halted}, {31'd0, m_halted});
    chk("R2/R3/R4/R5 mem_en", {31'd0, mem_en}, {31'd0, e_en});
    if (e_en) begin
      chk("R2/R3/R4 mem_wr", {31'd0, mem_wr}, {31'd0, e_wr});
      chk("R2/R3/R4/R6 mem_addr", {16'd0, mem_addr}, {16'd0, e_addr});
      if (e_wr) chk("R4 mem_wdata", mem_wdata, m_rf[cur[18:16]]);
    end
  endtask

  // runs with the reference every clock; stop_after>0 aborts early
  task automatic run_prog(input int stop_after);
    int idle = 0;
    int n = 0;
    m_reset();
    forever begin
      compare_cycle();
      n++;
      if (stop_after > 0 && n >= stop_after) break;
      if (m_halted) begin
        idle++;
        if (idle >= 6) break;
      end else begin
        m_cycles++;
        m_k++;
        if (m_k == m_len) m_finish_instr();
      end
      @(negedge clk);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin ram[i] = '0; m_mem[i] = '0; end
  endtask

  task automatic put(input int a, input logic [31:0] w);
    ram[a] = w; m_mem[a] = w;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset cycle_count", cycle_count, 0);
    chk("R1 reset retired_count", retired_count, 0);
    chk("R1 reset halted", {31'd0, halted}, 0);
    rst = 1'b0;
  endtask

  task automatic compare_mem(input string rq);
    for (int i = 0; i < 256; i++) chk(rq, ram[i], m_mem[i]);
  endtask

  task automatic load_prog2();
    clear_mem();
    put(0,  enc(3'b010, 4, 1, 16'd50));           // lw r1 <- mem[50]
    put(1,  enc(3'b010, 4, 2, 16'd51));           // lw r2 <- mem[51]
    put(2,  enc(3'b010, 4, 6, 16'd52));           // lw r6 <- -1
    put(3,  enc(3'b000, 1, 2, 16'd0));            // add r0 = r1+r2 (R7)
    put(4,  enc(3'b001, 1, 0, 16'd3));            // nor r3 = r1 nor r0
    put(5,  enc(3'b011, 4, 3, 16'd60));           // sw r3 -> mem[60]
    put(6,  enc(3'b011, 4, 0, 16'd61));           // sw r0 -> mem[61]
    put(7,  enc(3'b000, 1, 6, 16'd1));            // r1 = r1 - 1
    put(8,  enc(3'b100, 1, 4, 16'd2));            // exit to 11 when r1==0
    put(9,  enc(3'b100, 4, 4, 16'hFFFD));         // back to 7
    put(10, enc(3'b111, 0, 0, 16'd0));
    put(11, enc(3'b011, 4, 1, 16'd62));           // sw r1 -> mem[62]
    put(12, enc(3'b010, 2, 7, 16'hFFFF));         // lw r7 <- mem[r2-1]
    put(13, enc(3'b011, 4, 7, 16'd63));           // sw r7 -> mem[63]
    put(14, enc(3'b101, 1, 1, 16'd5));            // unused opcode: no effect
    put(15, enc(3'b111, 2, 2, 16'd5));            // noop
    put(16, enc(3'b110, 0, 0, 16'd0));            // halt
    put(50, 32'd7);
    put(51, 32'd3);
    put(52, 32'hFFFF_FFFF);
  endtask

  initial begin
    // program 1: instruction mix for the cycle budget
    clear_mem();
    for (int i = 0; i < 100; i++) begin
      if (i % 4 == 0)
        put(i, enc(3'b010, 0, 1 + (i/4) % 3, 16'(200 + (i/4) % 8)));
      else if (i % 4 == 1 && i < 80)
        put(i, enc(3'b100, 1, 2, 16'd0));
      else if (i % 4 == 2 && i < 40)
        put(i, enc(3'b011, 0, 4, 16'(220 + i/4)));
      else
        put(i, enc(3'b000, 1, 2, 16'(4 + i % 3)));
    end
    put(100, enc(3'b110, 0, 0, 16'd0));
    for (int i = 0; i < 8; i++) put(200 + i, 32'(i * 3 + 1));
    apply_reset();
    run_prog(0);
    chk("R9 mix cycles", cycle_count, 427);
    chk("R9 mix retired", retired_count, 101);
    compare_mem("R4 mix memory");

    // program 2: fields, register 0, loops, negative offsets
    load_prog2();
    apply_reset();
    run_prog(0);
    chk("R5/R10 nor result", ram[60], 32'hFFFF_FFF0);
    chk("R7 r0 stored", ram[61], 32'd10);
    chk("R6 loop exit value", ram[62], 32'd0);
    chk("R3 negative offset load", ram[63], enc(3'b010, 4, 6, 16'd52));
    compare_mem("R8 program memory");
    @(negedge clk);
    chk("R8 halted idle port", {31'd0, mem_en}, 0);

    // program 3: reset in mid-run, then full rerun
    load_prog2();
    apply_reset();
    run_prog(12);
    apply_reset();
    chk("R1 fetch after reset en", {31'd0, mem_en}, 1);
    chk("R1 fetch after reset addr", {16'd0, mem_addr}, 0);
    load_prog2();
    run_prog(0);
    compare_mem("R1 rerun memory");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule